// File: doc/BRIEF.md
# Thermal Threshold Interrupt Unit

This block watches an 8-bit temperature code and compares it against eight programmable trigger levels. Each level has a rising threshold and a lower falling threshold, which together form a hysteresis band. A level "arms" when the code climbs to or past its rising threshold, and it disarms when the code sinks to or below its falling threshold. Each of these transitions records a pending bit: one bit for rising and one for falling, per level. The interrupt line is the OR of the pending bits that software has enabled. Software clears pending bits by writing ones to a separate clear register, which has the same bit layout.

Temperature codes enter on a valid-qualified input. The block samples a code on every cycle where the valid signal is high, so it never applies back-pressure and has no ready signal. An emulation register can substitute a programmed code for the sensor. While emulation is on, the comparators use that code on every cycle, whatever the valid signal does. A control register holds the core enable bit and the hardware-trip controls. When hardware trip is armed and enabled, a chosen level drives the trip output directly, regardless of the interrupt mask. A ready flag in the state register drops for a short, fixed time after core enable is toggled.

Register access is a simple 32-bit port. Writes take effect at the clock edge. Reads are combinational from the address.

Top module: `thermal_irq_unit`

## Requirements
- R1: After reset, every register reads 0 except the state register, which reads 1 (ready). `irq_o` and `trip_o` are low.
- R2: On a compare cycle, a level that is disarmed and sees a code ≥ its rising threshold sets pending bit i (address 2) at that clock edge and becomes armed. An armed level sets no further rise bits.
- R3: On a compare cycle, an armed level that sees a code ≤ its falling threshold sets pending bit 8+i and becomes disarmed. A level that was never armed never sets a fall bit.
- R4: Rising thresholds for levels 0–3 sit at address 8 and levels 4–7 at address 9, with level i in bits [8(i%4)+7 : 8(i%4)]. Falling thresholds use the same packing at addresses 12 and 13. All four registers read back what was written.
- R5: Writing to the clear register (address 3) clears each pending bit written as 1 and leaves the others unchanged. The clear register reads 0. If a new event and a clear hit the same bit at the same edge, the bit ends set.
- R6: `irq_o` is high exactly when (pending AND enable) is nonzero. The enable register is at address 4 and uses the pending layout. Pending bits set whatever the enable mask holds.
- R7: The emulation register is at address 5: bit 0 enables emulation and bits [15:8] hold the code. While emulation is enabled, every cycle with core enabled is a compare cycle that uses the emulated code.
- R8: The control register is at address 0: bit 1 is trip enable, bit 2 arms hardware trip, and bits [6:4] select the trip level. `trip_o` is high exactly when both bit 1 and bit 2 are set and the selected level is armed. The enable mask has no effect on `trip_o`.
- R9: A control write that changes bit 0 (core enable) drives ready (address 1, bit 0) low for exactly 4 cycles, after which it returns high. A control write that leaves bit 0 unchanged keeps ready high.
- R10: While core enable is 0, no compare cycles occur: sensor codes change neither the pending bits nor the armed state.
- R11: When emulation is off, a cycle is a compare cycle only if `sns_valid` is high. A code presented with `sns_valid` low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sns_valid | input | 1 | Sensor code valid; the code is always accepted |
| sns_code | input | 8 | Live temperature code |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| irq_o | output | 1 | Interrupt: any enabled pending bit |
| trip_o | output | 1 | Hardware thermal trip |

## Verification
The hardest situation to create is a clear-register write that lands on the same edge as a fresh rise event for the bit being cleared. Creating it from the ports requires both a disarmed level and a sample above that level's threshold in the same cycle as the write. The stimulus first takes every level through a full rise-and-fall cycle to disarm them. It then drives the clear write and a sensor sample over level 0's threshold from the same falling edge. The expected result is that only bit 0 stays set.

// File: rtl/thermal_irq_pkg.sv
package thermal_irq_pkg;
  localparam int ADDR_W    = 4;
  localparam int DATA_W    = 32;
  localparam int A_CTRL    = 0;
  localparam int A_STATE   = 1;
  localparam int A_PEND    = 2;
  localparam int A_CLEAR   = 3;
  localparam int A_ENABLE  = 4;
  localparam int A_EMUL    = 5;
  localparam int A_RISE    = 8;
  localparam int A_FALL    = 12;
  localparam int MAX_TREGS = 4;

  typedef struct packed {
    logic [2:0] trip_lvl;
    logic       trip_arm;
    logic       trip_en;
    logic       core_en;
  } ctrl_t;
endpackage

// File: rtl/thermal_irq_level.sv
module thermal_irq_level #(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmp_en,
  input  logic [CODE_W-1:0] code,
  input  logic [CODE_W-1:0] rise_thr,
  input  logic [CODE_W-1:0] fall_thr,
  output logic              rise_ev,
  output logic              fall_ev,
  output logic              armed
);
  logic armed_q;

  assign rise_ev = cmp_en && !armed_q && (code >= rise_thr);
  assign fall_ev = cmp_en &&  armed_q && (code <= fall_thr);
  assign armed   = armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       armed_q <= 1'b0;
    else if (rise_ev) armed_q <= 1'b1;
    else if (fall_ev) armed_q <= 1'b0;
  end

  a_r2_rise_arms: assert property (@(posedge clk) disable iff (!rst_n)
    rise_ev |=> armed_q);
  a_r3_fall_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    fall_ev |=> !armed_q);
  a_r10_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_en |=> $stable(armed_q));
endmodule

// File: rtl/thermal_irq_ready.sv
module thermal_irq_ready #(
  parameter int HOLD = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic ready
);
  localparam int CNT_W = $clog2(HOLD + 1);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (start)      cnt_q <= CNT_W'(HOLD);
    else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
  end

  assign ready = (cnt_q == '0);

  a_r9_low_after_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !ready);
endmodule

// File: rtl/thermal_irq_regs.sv
module thermal_irq_regs
  import thermal_irq_pkg::*;
#(
  parameter int N_LVL  = 8,
  parameter int CODE_W = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         reg_wr,
  input  logic [ADDR_W-1:0]            reg_addr,
  input  logic [DATA_W-1:0]            reg_wdata,
  output logic [DATA_W-1:0]            reg_rdata,
  input  logic                         ready,
  input  logic [2*N_LVL-1:0]           events,
  output ctrl_t                        ctrl,
  output logic                         core_toggle,
  output logic [2*N_LVL-1:0]           pend,
  output logic [2*N_LVL-1:0]           ien,
  output logic                         emul_en,
  output logic [CODE_W-1:0]            emul_code,
  output logic [N_LVL-1:0][CODE_W-1:0] rise_thr,
  output logic [N_LVL-1:0][CODE_W-1:0] fall_thr
);
  localparam int LPR   = DATA_W / CODE_W;
  localparam int PEND_W = 2 * N_LVL;

  logic wr_ctrl, wr_clear, wr_ien, wr_emul;
  logic [PEND_W-1:0] clr_mask;

  assign wr_ctrl     = reg_wr && (reg_addr == ADDR_W'(A_CTRL));
  assign wr_clear    = reg_wr && (reg_addr == ADDR_W'(A_CLEAR));
  assign wr_ien      = reg_wr && (reg_addr == ADDR_W'(A_ENABLE));
  assign wr_emul     = reg_wr && (reg_addr == ADDR_W'(A_EMUL));
  assign clr_mask    = wr_clear ? reg_wdata[PEND_W-1:0] : '0;
  assign core_toggle = wr_ctrl && (reg_wdata[0] != ctrl.core_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl      <= '0;
      ien       <= '0;
      emul_en   <= 1'b0;
      emul_code <= '0;
      pend      <= '0;
    end else begin
      if (wr_ctrl) begin
        ctrl.core_en  <= reg_wdata[0];
        ctrl.trip_en  <= reg_wdata[1];
        ctrl.trip_arm <= reg_wdata[2];
        ctrl.trip_lvl <= reg_wdata[6:4];
      end
      if (wr_ien) ien <= reg_wdata[PEND_W-1:0];
      if (wr_emul) begin
        emul_en   <= reg_wdata[0];
        emul_code <= reg_wdata[8 +: CODE_W];
      end
      pend <= (pend & ~clr_mask) | events;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_thr <= '0;
      fall_thr <= '0;
    end else if (reg_wr) begin
      for (int i = 0; i < N_LVL; i++) begin
        if (reg_addr == ADDR_W'(A_RISE + i / LPR))
          rise_thr[i] <= reg_wdata[(i % LPR) * CODE_W +: CODE_W];
        if (reg_addr == ADDR_W'(A_FALL + i / LPR))
          fall_thr[i] <= reg_wdata[(i % LPR) * CODE_W +: CODE_W];
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADDR_W'(A_CTRL): begin
        reg_rdata[0]   = ctrl.core_en;
        reg_rdata[1]   = ctrl.trip_en;
        reg_rdata[2]   = ctrl.trip_arm;
        reg_rdata[6:4] = ctrl.trip_lvl;
      end
      ADDR_W'(A_STATE):  reg_rdata[0] = ready;
      ADDR_W'(A_PEND):   reg_rdata[PEND_W-1:0] = pend;
      ADDR_W'(A_ENABLE): reg_rdata[PEND_W-1:0] = ien;
      ADDR_W'(A_EMUL): begin
        reg_rdata[0]             = emul_en;
        reg_rdata[8 +: CODE_W]   = emul_code;
      end
      default: begin
        for (int i = 0; i < N_LVL; i++) begin
          if (reg_addr == ADDR_W'(A_RISE + i / LPR))
            reg_rdata[(i % LPR) * CODE_W +: CODE_W] = rise_thr[i];
          if (reg_addr == ADDR_W'(A_FALL + i / LPR))
            reg_rdata[(i % LPR) * CODE_W +: CODE_W] = fall_thr[i];
        end
      end
    endcase
  end

  a_r5_event_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (events != '0) |=> ((pend & $past(events)) == $past(events)));
  a_r5_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_clear && events == '0) |=> ((pend & $past(clr_mask)) == '0));
endmodule

// File: rtl/thermal_irq_unit.sv
module thermal_irq_unit
  import thermal_irq_pkg::*;
#(
  parameter int N_LVL      = 8,
  parameter int CODE_W     = 8,
  parameter int READY_HOLD = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sns_valid,
  input  logic [CODE_W-1:0] sns_code,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_o,
  output logic              trip_o
);
  localparam int LVL_W = (N_LVL > 1) ? $clog2(N_LVL) : 1;

  ctrl_t                        ctrl;
  logic                         core_toggle, ready, emul_en, cmp_en;
  logic [CODE_W-1:0]            emul_code, eff_code;
  logic [2*N_LVL-1:0]           pend, ien, events;
  logic [N_LVL-1:0][CODE_W-1:0] rise_thr, fall_thr;
  logic [N_LVL-1:0]             armed;

  thermal_irq_regs #(.N_LVL(N_LVL), .CODE_W(CODE_W)) u_regs (
    .clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata,
    .ready, .events, .ctrl, .core_toggle, .pend, .ien,
    .emul_en, .emul_code, .rise_thr, .fall_thr
  );

  thermal_irq_ready #(.HOLD(READY_HOLD)) u_ready (
    .clk, .rst_n, .start(core_toggle), .ready
  );

  assign eff_code = emul_en ? emul_code : sns_code;
  assign cmp_en   = ctrl.core_en && (emul_en || sns_valid);

  for (genvar g = 0; g < N_LVL; g++) begin : g_lvl
    thermal_irq_level #(.CODE_W(CODE_W)) u_lvl (
      .clk, .rst_n, .cmp_en, .code(eff_code),
      .rise_thr(rise_thr[g]), .fall_thr(fall_thr[g]),
      .rise_ev(events[g]), .fall_ev(events[N_LVL + g]),
      .armed(armed[g])
    );
  end

  assign irq_o  = |(pend & ien);
  assign trip_o = ctrl.trip_en && ctrl.trip_arm && armed[ctrl.trip_lvl[LVL_W-1:0]];

  a_r10_no_event_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.core_en |-> (events == '0));
  a_r11_no_event_without_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (!emul_en && !sns_valid) |-> (events == '0));
endmodule

// File: tb/test_thermal_irq_unit.sv
module test_thermal_irq_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sns_valid = 1'b0;
  logic [7:0]  sns_code = '0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_o, trip_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  thermal_irq_unit i_thermal_irq_unit (
    .clk, .rst_n, .sns_valid, .sns_code, .reg_wr, .reg_addr,
    .reg_wdata, .reg_rdata, .irq_o, .trip_o
  );

  localparam int NV = 8;
  localparam logic [7:0]  V_CODE [NV] = '{8'd25, 8'd65, 8'd65, 8'd35, 8'd30, 8'd40, 8'd165, 8'd5};
  localparam logic [15:0] V_PEND [NV] = '{16'h0001, 16'h0007, 16'h0007, 16'h0407,
                                          16'h0607, 16'h0607, 16'h06FF, 16'hFFFF};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic sample(input logic v, input logic [7:0] c);
    @(negedge clk);
    sns_valid = v; sns_code = c;
    @(negedge clk);
    sns_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    rd(4'd0, d);  check("R1 ctrl", d, 32'h0);
    rd(4'd1, d);  check("R1 ready", d, 32'h1);
    rd(4'd2, d);  check("R1 pend", d, 32'h0);
    rd(4'd8, d);  check("R1 rise thr", d, 32'h0);
    check("R1 irq/trip", {30'd0, irq_o, trip_o}, 32'h0);

    // R4 threshold packing
    wr(4'd8,  32'h503C2814);
    wr(4'd9,  32'hA08C7864);
    wr(4'd12, 32'h46321E0A);
    wr(4'd13, 32'h96826E5A);
    rd(4'd8,  d); check("R4 rise lo", d, 32'h503C2814);
    rd(4'd9,  d); check("R4 rise hi", d, 32'hA08C7864);
    rd(4'd12, d); check("R4 fall lo", d, 32'h46321E0A);
    rd(4'd13, d); check("R4 fall hi", d, 32'h96826E5A);

    wr(4'd0, 32'h1);
    idle(6);

    // R2 R3 R6: table walk with enables at zero
    for (int k = 0; k < NV; k++) begin
      sample(1'b1, V_CODE[k]);
      rd(4'd2, d);
      check($sformatf("R2/R3 step %0d", k), d, {16'h0, V_PEND[k]});
    end
    check("R6 irq masked", {31'd0, irq_o}, 32'h0);

    // R5 clear
    wr(4'd3, 32'h000000F0);
    rd(4'd2, d); check("R5 w1c", d, 32'h0000FF0F);
    rd(4'd3, d); check("R5 clear reads 0", d, 32'h0);

    // R6 enable mask
    wr(4'd4, 32'h00000100);
    check("R6 irq on", {31'd0, irq_o}, 32'h1);
    wr(4'd4, 32'h000000F0);
    check("R6 irq off", {31'd0, irq_o}, 32'h0);
    wr(4'd4, 32'h0);

    // R5 collision: clear all and a level-0 rise at the same edge
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 4'd3; reg_wdata = 32'hFFFF;
    sns_valid = 1'b1; sns_code = 8'd25;
    @(negedge clk);
    reg_wr = 1'b0; sns_valid = 1'b0;
    rd(4'd2, d); check("R5 event wins", d, 32'h1);

    // R9 ready
    wr(4'd0, 32'h1);
    rd(4'd1, d); check("R9 no toggle", d, 32'h1);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 4'd0; reg_wdata = 32'h0;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = 4'd1;
    for (int k = 0; k < 4; k++) begin
      #1 check($sformatf("R9 low cycle %0d", k), {31'd0, reg_rdata[0]}, 32'h0);
      @(negedge clk);
    end
    #1 check("R9 back high", {31'd0, reg_rdata[0]}, 32'h1);

    // R10 core off
    wr(4'd3, 32'hFFFF);
    sample(1'b1, 8'd200);
    rd(4'd2, d); check("R10 no event when off", d, 32'h0);
    wr(4'd0, 32'h1);
    idle(5);

    // R11 invalid sample ignored
    sample(1'b0, 8'd200);
    rd(4'd2, d); check("R11 invalid ignored", d, 32'h0);

    // R7 emulation, code 100 with no valid samples
    wr(4'd5, 32'h00006401);
    idle(2);
    rd(4'd2, d); check("R7 emul compare", d, 32'h0000001E);

    // R8 hardware trip on level 4, enable mask zero
    wr(4'd0, 32'h47);
    check("R8 trip on", {31'd0, trip_o}, 32'h1);
    wr(4'd0, 32'h45);
    check("R8 trip_en off", {31'd0, trip_o}, 32'h0);
    wr(4'd0, 32'h47);
    wr(4'd5, 32'h00000001);
    idle(2);
    check("R8 trip after fall", {31'd0, trip_o}, 32'h0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule